// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block is the digital front end of a two-channel converter with 16-bit codes. A parallel data bus, a two-bit channel address, an active-low write strobe and a load strobe are sampled on every rising edge of the system clock. Each channel keeps two register stages: a staging register that the bus writes, and an output register whose code drives the converter.

The address decode is irregular. One code selects channel A, one selects channel B, one selects both channels, and one selects none. The two strobes together choose one of four operations:
- stage bus data into the addressed staging registers,
- copy both staging registers into both output registers,
- pass bus data straight through both stages of the addressed channels,
- do nothing.

Two active-low resets force every register to a common value. One is the power-on reset and the other is the clear pin. A select pin chooses that value: zero scale or midscale. Both resets act asynchronously.

Top module: `dual_dac_latch`

## Requirements
- R1: While `clrN` is low, all four registers hold 0x0000 if `midSel` is 0 and 0x8000 if `midSel` is 1, whatever `wrN`, `ldac` and `addr` are.
- R2: While `porN` is low, the registers take the same value that R1 gives.
- R3: With `wrN`=0 and `ldac`=0 at a clock edge, the addressed staging registers capture `dataIn` and neither output code changes.
- R4: With `wrN`=1 and `ldac`=1 at a clock edge, each output register copies its own staging register, whatever `addr` is.
- R5: With `wrN`=0 and `ldac`=1 at a clock edge, the staging and output registers of the addressed channels both take `dataIn`; a channel that is not addressed keeps both of its registers.
- R6: With `wrN`=1 and `ldac`=0 at a clock edge, no register changes.
- R7: The channel selected by `addr`:

  | `addr` | Channels |
  |---|---|
  | 2'b00 | A only |
  | 2'b01 | none |
  | 2'b10 | A and B |
  | 2'b11 | B only |

- R8: When both resets are high, `codeA` and `codeB` change only at a rising clock edge. They show the inputs sampled at that edge.
- R9: At the first clock edge after both resets are high again, the block performs the operation that the strobes select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| clrN | input | 1 | Clear pin, active low, asynchronous |
| midSel | input | 1 | Reset value select: 0 gives zero scale, 1 gives midscale |
| wrN | input | 1 | Write strobe, active low |
| ldac | input | 1 | Load strobe, active high |
| addr | input | 2 | Channel address |
| dataIn | input | 16 | Parallel data bus |
| codeA | output | 16 | Channel A output register |
| codeB | output | 16 | Channel B output register |

## Verification
The bound checker watches the following on every cycle:
- the reset value while a reset is held,
- that the output codes hold during the hold and staging operations and for the unselected address,
- that pass-through reaches the right channels one cycle later,
- that a staged value reaches both outputs after a copy.

Three behaviours show up only through the bench's scenarios, because the staging registers are never visible at the ports:
- a single channel is staged and then copied,
- a later staging write overwrites an earlier one,
- a pass-through to one channel leaves the other channel's staging register alone.

The bench's cycle model tracks all four registers through long mixed sequences with resets at random points. Any difference in that hidden state therefore appears at a later copy.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_STAGE = 2'd1,
    MODE_XFER  = 2'd2,
    MODE_THRU  = 2'd3
  } regMode_t;

  typedef struct packed {
    logic [NUM_CH-1:0] stageLoad;   // staging register captures the bus
    logic [NUM_CH-1:0] outFromBus;  // output register captures the bus
    logic [NUM_CH-1:0] outFromStage; // output register copies its staging register
  } regStrobes_t;

  // Channel select mask: bit 0 is channel A, bit 1 is channel B.
  function automatic logic [NUM_CH-1:0] decodeAddr(input logic [1:0] a);
    logic [NUM_CH-1:0] m;
    unique case (a)
      2'b00:   m = 2'b01;
      2'b01:   m = 2'b00;
      2'b10:   m = 2'b11;
      default: m = 2'b10;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
  import dacreg_pkg::*;
(
  input  logic        wrN,
  input  logic        ldac,
  input  logic [1:0]  addr,
  output regMode_t    mode,
  output regStrobes_t strobes
);

  logic [NUM_CH-1:0] chanSel;

  always_comb begin
    unique case ({wrN, ldac})
      2'b00:   mode = MODE_STAGE;
      2'b01:   mode = MODE_THRU;
      2'b11:   mode = MODE_XFER;
      default: mode = MODE_HOLD;
    endcase
  end

  assign chanSel = decodeAddr(addr);

  always_comb begin
    strobes = '0;
    unique case (mode)
      MODE_STAGE: strobes.stageLoad = chanSel;
      MODE_THRU: begin
        strobes.stageLoad  = chanSel;
        strobes.outFromBus = chanSel;
      end
      MODE_XFER:  strobes.outFromStage = '1;
      default:    strobes = '0;
    endcase
  end

endmodule

// File: rtl/dacreg_path.sv
module dacreg_path
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     midSel,
  input  regStrobes_t              strobes,
  input  logic [DATA_W-1:0]        busData,
  output logic [NUM_CH-1:0][DATA_W-1:0] outCode
);

  localparam logic [DATA_W-2:0] LOW_ZERO = '0;

  logic [DATA_W-1:0] rstCode;
  assign rstCode = {midSel, LOW_ZERO};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] stageReg;
    logic [DATA_W-1:0] outReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageReg <= rstCode;
      end else if (strobes.stageLoad[ch]) begin
        stageReg <= busData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg <= rstCode;
      end else if (strobes.outFromBus[ch]) begin
        outReg <= busData;
      end else if (strobes.outFromStage[ch]) begin
        outReg <= stageReg;
      end
    end

    assign outCode[ch] = outReg;
  end

endmodule

// File: rtl/dual_dac_latch.sv
module dual_dac_latch
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              clrN,
  input  logic              midSel,
  input  logic              wrN,
  input  logic              ldac,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] codeA,
  output logic [DATA_W-1:0] codeB
);

  regMode_t    mode;
  regStrobes_t strobes;
  logic        rstN;
  logic [NUM_CH-1:0][DATA_W-1:0] outCode;

  assign rstN = porN & clrN;

  dacreg_ctrl u_ctrl (
    .wrN     (wrN),
    .ldac    (ldac),
    .addr    (addr),
    .mode    (mode),
    .strobes (strobes)
  );

  dacreg_path #(.DATA_W(DATA_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .midSel  (midSel),
    .strobes (strobes),
    .busData (dataIn),
    .outCode (outCode)
  );

  assign codeA = outCode[0];
  assign codeB = outCode[1];

endmodule

// File: rtl/dual_dac_latch_chk.sv
module dual_dac_latch_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              porN,
  input logic              clrN,
  input logic              midSel,
  input logic              wrN,
  input logic              ldac,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] codeA,
  input logic [DATA_W-1:0] codeB
);

  localparam logic [DATA_W-2:0] LOW_ZERO = '0;

  logic       rstN;
  logic       heldRst;
  logic [1:0] sinceRst;
  logic       warm;

  assign rstN = porN & clrN;
  assign warm = (sinceRst == 2'd3);

  always_ff @(posedge clk) heldRst <= !rstN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1 / R2: reset value while either reset is held
  assert_reset_value_R1: assert property (@(posedge clk)
    (heldRst && !rstN && $stable(midSel)) |->
      (codeA == {midSel, LOW_ZERO} && codeB == {midSel, LOW_ZERO}));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrN && !ldac) |=> ($stable(codeA) && $stable(codeB)));

  assert_stage_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && !ldac) |=> ($stable(codeA) && $stable(codeB)));

  assert_no_channel_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && ldac && addr == 2'b01) |=> ($stable(codeA) && $stable(codeB)));

  assert_thru_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && ldac && addr == 2'b00) |=> (codeA == $past(dataIn) && $stable(codeB)));

  assert_thru_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && ldac && addr == 2'b11) |=> (codeB == $past(dataIn) && $stable(codeA)));

  assert_thru_both_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && ldac && addr == 2'b10) |=> (codeA == $past(dataIn) && codeB == $past(dataIn)));

  assert_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(!wrN && !ldac && addr == 2'b10) && wrN && ldac) |=>
      (codeA == $past(dataIn, 2) && codeB == $past(dataIn, 2)));

endmodule

bind dual_dac_latch dual_dac_latch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .porN   (porN),
  .clrN   (clrN),
  .midSel (midSel),
  .wrN    (wrN),
  .ldac   (ldac),
  .addr   (addr),
  .dataIn (dataIn),
  .codeA  (codeA),
  .codeB  (codeB)
);

// File: tb/sim_dual_dac_latch.sv
module sim_dual_dac_latch;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        clrN = 1'b1;
  logic        midSel = 1'b1;
  logic        wrN = 1'b1;
  logic        ldac = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic [15:0] dataIn = 16'h0000;
  logic [15:0] codeA, codeB;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state: index 0 = A, 1 = B
  int stg[2];
  int out[2];
  string lastTag = "R2";
  bit wasRst = 1'b1;

  always #2 clk = ~clk;   // 250 MHz

  dual_dac_latch u0 (
    .clk(clk), .porN(porN), .clrN(clrN), .midSel(midSel),
    .wrN(wrN), .ldac(ldac), .addr(addr), .dataIn(dataIn),
    .codeA(codeA), .codeB(codeB)
  );

  function automatic bit selects(input logic [1:0] a, input int ch);
    case (a)
      2'b00: return ch == 0;
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      default: return ch == 1;
    endcase
  endfunction

  // behavioural model, updated at each rising edge
  always @(posedge clk) begin
    int rv;
    rv = midSel ? 32'h8000 : 0;
    if (!porN || !clrN) begin
      for (int c = 0; c < 2; c++) begin stg[c] = rv; out[c] = rv; end
      lastTag = !clrN ? "R1" : "R2";
      wasRst = 1'b1;
    end else begin
      if (wrN && !ldac) lastTag = "R6";
      else if (!wrN && !ldac) begin
        lastTag = "R3";
        for (int c = 0; c < 2; c++) if (selects(addr, c)) stg[c] = dataIn;
      end else if (wrN && ldac) begin
        lastTag = "R4";
        for (int c = 0; c < 2; c++) out[c] = stg[c];
      end else begin
        lastTag = (addr == 2'b01 || addr == 2'b10) ? "R7" : "R5";
        for (int c = 0; c < 2; c++)
          if (selects(addr, c)) begin stg[c] = dataIn; out[c] = dataIn; end
      end
      if (wasRst) lastTag = "R9";
      wasRst = 1'b0;
    end
  end

  // compare away from the active edge (R8: outputs reflect last edge)
  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      compared++;
      if (codeA !== out[0][15:0] || codeB !== out[1][15:0]) begin
        mismatched++;
        $display("FAIL %s (R8 timing) cycle %0d: codeA=%h codeB=%h expected %h %h",
                 lastTag, cycles, codeA, codeB, out[0][15:0], out[1][15:0]);
      end
    end
    cycles++;
    if (cycles > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic step(input logic w, input logic l, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wrN = w; ldac = l; addr = a; dataIn = d;
  endtask

  initial begin
    // R2: power-on reset to midscale, strobes active
    step(1'b0, 1'b1, 2'b10, 16'h1234);
    step(1'b0, 1'b1, 2'b10, 16'h1234);
    @(negedge clk); #1; porN = 1'b1;
    // R9 first edge after release: pass-through to both
    wrN = 1'b0; ldac = 1'b1; addr = 2'b10; dataIn = 16'hA5A5;
    // R7 no-channel pass-through
    step(1'b0, 1'b1, 2'b01, 16'hFFFF);
    // R5 pass-through A only, then B only
    step(1'b0, 1'b1, 2'b00, 16'h1111);
    step(1'b0, 1'b1, 2'b11, 16'h2222);
    // R3 stage A, overwrite A, stage B; outputs quiet
    step(1'b0, 1'b0, 2'b00, 16'h3333);
    step(1'b0, 1'b0, 2'b00, 16'h4444);
    step(1'b0, 1'b0, 2'b11, 16'h5555);
    // R6 hold with bus toggling
    step(1'b1, 1'b0, 2'b10, 16'hDEAD);
    // R4 copy both
    step(1'b1, 1'b1, 2'b01, 16'hBEEF);
    // R7 stage both via 10, address 01 stage ignored, then copy
    step(1'b0, 1'b0, 2'b10, 16'h6666);
    step(1'b0, 1'b0, 2'b01, 16'h7777);
    step(1'b1, 1'b1, 2'b00, 16'h0000);
    step(1'b1, 1'b0, 2'b00, 16'h0000);
    // R1: clear to zero scale mid-operation
    @(negedge clk); #1; midSel = 1'b0; clrN = 1'b0; wrN = 1'b0; ldac = 1'b1;
    step(1'b1, 1'b1, 2'b10, 16'h9999);
    @(negedge clk); #1; clrN = 1'b1;
    step(1'b1, 1'b1, 2'b00, 16'h0000);
    // mixed random traffic with occasional resets
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      wrN = 1'($urandom); ldac = 1'($urandom);
      addr = 2'($urandom); dataIn = 16'($urandom);
      if (($urandom % 97) == 0) midSel = 1'($urandom);
      clrN = (($urandom % 53) != 0);
      porN = (($urandom % 211) != 0);
    end
    @(negedge clk); #1; clrN = 1'b1; porN = 1'b1;
    step(1'b1, 1'b0, 2'b00, 16'h0000);
    step(1'b1, 1'b0, 2'b00, 16'h0000);
    @(negedge clk);
    finish_run();
  end

endmodule